// File: doc/BRIEF.md
# Display Pipeline Self-Refresh Controller

This block governs the fetch path of a single video pipeline. Frame by frame, it decides whether pixels stream in from system memory, whether they stream in while also being written into the pipeline's local line/frame buffer, or whether the whole frame is replayed from that buffer with no memory traffic at all. Each pipeline carries its own copy of the block, so one pipeline can sit in replay while a neighbour keeps fetching for the whole scan.

Software controls the block with a self-refresh enable, an auto-enable control and a per-port update request ("go") bit. Setting go asks for the next frame to be captured. Hardware clears go once both the last fetch and the frame end have been seen. In manual operation, software polls go, sets self-refresh, and the pipeline switches to replay at the following frame start. In automatic operation, software only clears self-refresh. Hardware then captures one frame and sets the enable again itself on the frame start where replay begins. Every mode change is applied on a frame-start strobe, so no frame mixes fetched and replayed pixels.

Top module: `display_self_refresh`

## Requirements
- R1: After reset, sr_o=0, auto_o=0, go_o=0, state_o=0 (FETCH) and fetch_req_o=1.
- R2: In FETCH (state_o=0), fetch_req_o=1, buf_we_o=0 and replay_sel_o=0.
- R3: When go_o=1 or (auto_o=1 and sr_o=0) at a frame start in FETCH, the block enters CAPTURE (state_o=1), with buf_we_o=1 and fetch_req_o=1.
- R4: A capture completes in the cycle where frame_end_i is high in CAPTURE and fetch_done_i has been high in that frame, either earlier or in the same cycle. go_o clears in the next cycle. frame_end_i arriving before fetch_done_i does not complete the capture.
- R5: state_o changes only in the cycle after a frame_start_i pulse. A register write between boundaries does not move the state.
- R6: REPLAY (state_o=2) is entered only at a frame start that follows a completed capture with sr_o=1 or auto_o=1. A software write of sr=1 during an unfinished capture waits for completion. A write of sr=1 in FETCH with no capture leaves the block in FETCH.
- R7: In REPLAY, fetch_req_o=0, replay_sel_o=1 and buf_we_o=0.
- R8: With sr_o=0 at a frame start in REPLAY, the block leaves replay. It goes to CAPTURE when go_o or auto_o is 1, and to FETCH otherwise.
- R9: With auto_o=1, sr_o reads 0 during the capture frame. Hardware sets sr_o to 1 in the cycle after the frame start that moves CAPTURE to REPLAY.
- R10: With auto_o=0, sr_o changes only through a software write.
- R11: A software write of sr in the same cycle as the hardware set takes priority. A go set in the same cycle as a capture completion leaves go_o=1.
- R12: state_o encodes FETCH=0, CAPTURE=1, REPLAY=2. The value 3 never appears.
- R13: A frame start in CAPTURE before completion keeps the block in CAPTURE and forgets any fetch_done_i already seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sr_wr_i | input | 1 | Software write strobe for the self-refresh enable |
| sr_wdata_i | input | 1 | Value written to the self-refresh enable |
| auto_wr_i | input | 1 | Software write strobe for the auto-enable control |
| auto_wdata_i | input | 1 | Value written to the auto-enable control |
| go_set_i | input | 1 | Software set of the go bit |
| frame_start_i | input | 1 | Frame-start strobe from the timing generator |
| frame_end_i | input | 1 | Frame-end strobe from the timing generator |
| fetch_done_i | input | 1 | Memory fetch for the current frame finished |
| fetch_req_o | output | 1 | Gate allowing memory fetch requests |
| buf_we_o | output | 1 | Local buffer write enable |
| replay_sel_o | output | 1 | Select buffer replay as the pixel source |
| sr_o | output | 1 | Self-refresh enable read-back |
| auto_o | output | 1 | Auto-enable read-back |
| go_o | output | 1 | Go bit read-back |
| state_o | output | 2 | Current mode (0 FETCH, 1 CAPTURE, 2 REPLAY) |

## Verification
Two pairs of events can land in the same cycle. The first is the automatic hardware set of the self-refresh bit and a software write of that bit: the bench drives a frame start that ends an automatic capture together with a write of 0. The expected result is that the software value is kept while the state still moves to REPLAY, so the pipeline then leaves replay at the next boundary. The second is a capture completion and a software go set in the same cycle: the bench drives frame end and fetch done together with a go set and expects go_o to stay high.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  typedef enum logic [1:0] {
    ST_FETCH   = 2'd0,
    ST_CAPTURE = 2'd1,
    ST_REPLAY  = 2'd2
  } dsr_state_e;
  localparam int unsigned StateW = 2;
endpackage

// File: rtl/dsr_ctrl_regs.sv
module dsr_ctrl_regs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sr_wr_i,
  input  logic sr_wdata_i,
  input  logic auto_wr_i,
  input  logic auto_wdata_i,
  input  logic go_set_i,
  input  logic cap_complete_i,
  input  logic hw_sr_set_i,
  output logic sr_q_o,
  output logic auto_q_o,
  output logic go_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q_o   <= 1'b0;
      auto_q_o <= 1'b0;
      go_q_o   <= 1'b0;
    end else begin
      // software write outranks hardware auto-set
      if (sr_wr_i)          sr_q_o <= sr_wdata_i;
      else if (hw_sr_set_i) sr_q_o <= 1'b1;
      if (auto_wr_i) auto_q_o <= auto_wdata_i;
      // a fresh request outranks completion clear
      if (go_set_i)            go_q_o <= 1'b1;
      else if (cap_complete_i) go_q_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dsr_capture_track.sv
module dsr_capture_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_capture_i,
  input  logic frame_start_i,
  input  logic frame_end_i,
  input  logic fetch_done_i,
  output logic cap_complete_o,
  output logic cap_done_q_o
);
  logic seen_q;

  assign cap_complete_o = in_capture_i && !cap_done_q_o && !frame_start_i &&
                          frame_end_i && (fetch_done_i || seen_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q       <= 1'b0;
      cap_done_q_o <= 1'b0;
    end else if (frame_start_i) begin
      seen_q       <= 1'b0;
      cap_done_q_o <= 1'b0;
    end else begin
      if (in_capture_i && fetch_done_i) seen_q <= 1'b1;
      if (cap_complete_o)               cap_done_q_o <= 1'b1;
    end
  end
endmodule

// File: rtl/dsr_fsm.sv
module dsr_fsm
  import dsr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_start_i,
  input  logic       sr_q_i,
  input  logic       auto_q_i,
  input  logic       go_q_i,
  input  logic       cap_done_q_i,
  output dsr_state_e state_q_o,
  output logic       hw_sr_set_o
);
  dsr_state_e state_d;
  logic       want_cap;

  assign want_cap = go_q_i || (auto_q_i && !sr_q_i);

  always_comb begin
    state_d = state_q_o;
    unique case (state_q_o)
      ST_FETCH:   state_d = want_cap ? ST_CAPTURE : ST_FETCH;
      ST_CAPTURE: begin
        if (!cap_done_q_i)              state_d = ST_CAPTURE;
        else if (sr_q_i || auto_q_i)    state_d = ST_REPLAY;
        else if (go_q_i)                state_d = ST_CAPTURE;
        else                            state_d = ST_FETCH;
      end
      ST_REPLAY: begin
        if (sr_q_i)                     state_d = ST_REPLAY;
        else if (go_q_i || auto_q_i)    state_d = ST_CAPTURE;
        else                            state_d = ST_FETCH;
      end
      default:                          state_d = ST_FETCH;
    endcase
  end

  assign hw_sr_set_o = frame_start_i && auto_q_i &&
                       (state_q_o == ST_CAPTURE) && (state_d == ST_REPLAY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            state_q_o <= ST_FETCH;
    else if (frame_start_i) state_q_o <= state_d;
  end
endmodule

// File: rtl/display_self_refresh.sv
module display_self_refresh
  import dsr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sr_wr_i,
  input  logic              sr_wdata_i,
  input  logic              auto_wr_i,
  input  logic              auto_wdata_i,
  input  logic              go_set_i,
  input  logic              frame_start_i,
  input  logic              frame_end_i,
  input  logic              fetch_done_i,
  output logic              fetch_req_o,
  output logic              buf_we_o,
  output logic              replay_sel_o,
  output logic              sr_o,
  output logic              auto_o,
  output logic              go_o,
  output logic [StateW-1:0] state_o
);
  dsr_state_e state_q;
  logic sr_q, auto_q, go_q, cap_complete, cap_done_q, hw_sr_set;

  dsr_ctrl_regs u_regs (
    .clk_i, .rst_ni, .sr_wr_i, .sr_wdata_i, .auto_wr_i, .auto_wdata_i, .go_set_i,
    .cap_complete_i(cap_complete),
    .hw_sr_set_i   (hw_sr_set),
    .sr_q_o        (sr_q),
    .auto_q_o      (auto_q),
    .go_q_o        (go_q)
  );

  dsr_capture_track u_track (
    .clk_i, .rst_ni,
    .in_capture_i  (state_q == ST_CAPTURE),
    .frame_start_i, .frame_end_i, .fetch_done_i,
    .cap_complete_o(cap_complete),
    .cap_done_q_o  (cap_done_q)
  );

  dsr_fsm u_fsm (
    .clk_i, .rst_ni, .frame_start_i,
    .sr_q_i      (sr_q),
    .auto_q_i    (auto_q),
    .go_q_i      (go_q),
    .cap_done_q_i(cap_done_q),
    .state_q_o   (state_q),
    .hw_sr_set_o (hw_sr_set)
  );

  assign fetch_req_o  = (state_q != ST_REPLAY);
  assign buf_we_o     = (state_q == ST_CAPTURE);
  assign replay_sel_o = (state_q == ST_REPLAY);
  assign sr_o         = sr_q;
  assign auto_o       = auto_q;
  assign go_o         = go_q;
  assign state_o      = state_q;
endmodule

// File: rtl/dsr_checker.sv
module dsr_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sr_wr_i,
  input logic       frame_start_i,
  input logic       frame_end_i,
  input logic       fetch_req_o,
  input logic       buf_we_o,
  input logic       replay_sel_o,
  input logic       sr_o,
  input logic       auto_o,
  input logic       go_o,
  input logic [1:0] state_o
);
  AST_STATE_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(state_o)); // R5
  AST_LEGAL_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'd3); // R12
  AST_REPLAY_AFTER_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(replay_sel_o) |-> $past(state_o) == 2'd1); // R6
  AST_GO_CLEAR_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(go_o) |-> ($past(buf_we_o) && $past(frame_end_i))); // R4
  AST_MANUAL_SR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!auto_o && !sr_wr_i) |=> $stable(sr_o)); // R10
  AST_REPLAY_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    replay_sel_o |-> (!buf_we_o && !fetch_req_o)); // R7
endmodule

bind display_self_refresh dsr_checker u_chk (
  .clk_i, .rst_ni, .sr_wr_i, .frame_start_i, .frame_end_i,
  .fetch_req_o, .buf_we_o, .replay_sel_o, .sr_o, .auto_o, .go_o, .state_o
);

// File: tb/sim_display_self_refresh.sv
module sim_display_self_refresh;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sr_wr = 0, sr_wd = 0, au_wr = 0, au_wd = 0, go_set = 0, fs = 0, fe = 0, fd = 0;
  logic fetch_req, buf_we, replay_sel, sr, au, go;
  logic [1:0] state;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  display_self_refresh u0 (
    .clk_i(clk), .rst_ni(rst_n), .sr_wr_i(sr_wr), .sr_wdata_i(sr_wd),
    .auto_wr_i(au_wr), .auto_wdata_i(au_wd), .go_set_i(go_set),
    .frame_start_i(fs), .frame_end_i(fe), .fetch_done_i(fd),
    .fetch_req_o(fetch_req), .buf_we_o(buf_we), .replay_sel_o(replay_sel),
    .sr_o(sr), .auto_o(au), .go_o(go), .state_o(state)
  );

  // behavioural reference: 0 fetch, 1 capture, 2 replay
  int m_mode = 0; bit m_sr = 0, m_au = 0, m_go = 0, m_seen = 0, m_full = 0;
  always @(posedge clk) if (rst_n) begin
    bit fin, hw; int nxt;
    fin = (m_mode == 1) && !m_full && !fs && fe && (fd || m_seen);
    nxt = m_mode;
    if (m_mode == 0) nxt = (m_go || (m_au && !m_sr)) ? 1 : 0;
    else if (m_mode == 1) begin
      if (m_full) nxt = (m_sr || m_au) ? 2 : (m_go ? 1 : 0);
    end else if (!m_sr) nxt = (m_go || m_au) ? 1 : 0;
    hw = fs && m_au && m_mode == 1 && nxt == 2;
    if (sr_wr) m_sr = sr_wd; else if (hw) m_sr = 1;
    if (au_wr) m_au = au_wd;
    if (go_set) m_go = 1; else if (fin) m_go = 0;
    if (fs) begin m_seen = 0; m_full = 0; m_mode = nxt; end
    else begin
      if (m_mode == 1 && fd) m_seen = 1;
      if (fin) m_full = 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R12 state", state, m_mode);
    chk("R2 fetch_req", fetch_req, m_mode != 2);
    chk("R3 buf_we", buf_we, m_mode == 1);
    chk("R7 replay_sel", replay_sel, m_mode == 2);
    chk("R9 sr", sr, m_sr);
    chk("R4 go", go, m_go);
    chk("R1 auto", au, m_au);
  end

  task automatic tick(bit s, bit e, bit d, bit g = 0, bit w = 0, bit wd = 0, bit aw = 0, bit ad = 0);
    @(negedge clk);
    fs = s; fe = e; fd = d; go_set = g; sr_wr = w; sr_wd = wd; au_wr = aw; au_wd = ad;
  endtask
  task automatic idle(int n = 1);
    for (int i = 0; i < n; i++) tick(0, 0, 0);
  endtask

  task automatic summary();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset sr", sr, 0); chk("R1 reset auto", au, 0); chk("R1 reset go", go, 0);
    chk("R1 reset state", state, 0); chk("R1 reset fetch_req", fetch_req, 1);
    rst_n = 1;
    idle(2); tick(1, 0, 0); idle();
    chk("R2 fetch mode", {fetch_req, buf_we, replay_sel}, 3'b100);
    // manual capture and entry
    tick(0, 0, 0, 1); idle();
    chk("R5 go alone keeps state", state, 0); chk("R4 go set", go, 1);
    tick(1, 0, 0); idle();
    chk("R3 capture", {state, buf_we, fetch_req}, {2'd1, 2'b11});
    tick(0, 0, 1); tick(0, 0, 0, 0, 1, 1); idle();
    chk("R4 go held before end", go, 1); chk("R6 sr held off", state, 1);
    tick(0, 1, 0); idle();
    chk("R4 go cleared", go, 0); chk("R5 no move at end", state, 1);
    tick(1, 0, 0); idle();
    chk("R6 replay entered", state, 2);
    chk("R7 replay outputs", {fetch_req, replay_sel, buf_we}, 3'b010);
    for (int f = 0; f < 4; f++) begin tick(1, 0, 0); idle(3); tick(0, 1, 0); end
    idle(); chk("R10 sr stable manual", sr, 1); chk("R6 stay replay", state, 2);
    tick(0, 0, 0, 0, 1, 0); idle(); chk("R5 write mid-frame", state, 2);
    tick(1, 0, 0); idle(); chk("R8 leave replay", state, 0);
    // sr=1 with no capture
    tick(0, 0, 0, 0, 1, 1); tick(1, 0, 0); idle();
    chk("R6 no capture no replay", state, 0);
    tick(0, 0, 0, 0, 1, 0);
    // end before done, then restart
    tick(0, 0, 0, 1); tick(1, 0, 0); idle();
    tick(0, 1, 0); tick(0, 0, 1); idle();
    chk("R4 end before done", go, 1);
    tick(1, 0, 0); idle(); chk("R13 capture retained", state, 1);
    tick(0, 1, 0); idle(); chk("R13 seen forgotten", go, 1);
    tick(0, 1, 1); idle(); chk("R4 same-cycle end+done", go, 0);
    tick(1, 0, 0); idle(); chk("R8 back to fetch", state, 0);
    // automatic mode
    tick(0, 0, 0, 0, 0, 0, 1, 1); tick(1, 0, 0); idle();
    chk("R3 auto capture", state, 1); chk("R9 sr low in capture", sr, 0);
    tick(0, 0, 1); tick(0, 1, 0); idle(); chk("R9 sr low before boundary", sr, 0);
    tick(1, 0, 0); idle();
    chk("R9 hw set sr", sr, 1); chk("R9 auto replay", state, 2);
    // collision: sw write vs hw set
    tick(0, 0, 0, 0, 1, 0); tick(1, 0, 0); idle(); chk("R8 auto recapture", state, 1);
    tick(0, 1, 1); tick(1, 0, 0, 0, 1, 0); idle();
    chk("R11 sw write wins", sr, 0); chk("R11 replay still entered", state, 2);
    tick(1, 0, 0); idle(); chk("R8 exit after sw clear", state, 1);
    tick(0, 1, 1, 1); idle(); chk("R11 go set wins", go, 1);
    idle(2);
    summary();
  end
endmodule